// File: doc/BRIEF.md
# Hypercube Message Router Node

This block is the packet router for one node of a binary hypercube network. Each node owns an address of `DIMS` bits and has one input link and one output link per dimension, plus a local port through which its processing cluster injects new packets and receives packets addressed to it. A packet carries a relative address on the links: the XOR of the node it sits at and the node it is heading for. Every 1 bit of that relative address is a dimension still to be crossed.

All accepted packets land in a small shared pool of message buffers (five by default). From there each one is sent on the lowest-numbered dimension still set in its relative address, with that bit cleared on the way out. A packet whose relative address is zero is ejected to the local port. When an output is busy, packets wait in the pool, and the oldest waiting packet always goes first. A new packet for the same destination, with the same combine mode, as one already waiting is folded into it by bitwise OR or by wrapping sum. Parity guards every packet, and its sense flips between the local port (even) and the wires (odd), so a word stuck at all zeros on a link shows up as an error. A packet that fails parity is taken in and thrown away. A sticky flag and a saturating counter record the loss.

Top module: `hc_router`

## Requirements
- R1: A packet whose relative address is nonzero leaves on the output link of the lowest set bit d of that address, carrying the same address with bit d cleared, the same mode and the same data. Injected packets use relative address = destination XOR `node_id`.
- R2: A packet whose relative address is zero leaves on the eject port with a relative address field of zero.
- R3: Link words are `{rel[DIMS-1:0], mode, data[DATA_W-1:0], par}`, MSB first, and have an odd count of ones. Eject words use the same layout with an even count of ones. An injected packet is valid when `{inj_dest, inj_mode, inj_data, inj_par}` has an even count of ones.
- R4: An input packet that fails its parity rule is accepted and dropped: no output carries it, `err_flag` sets and stays set until reset, and `drop_cnt` increments (saturating).
- R5: The pool holds `NBUF` (default 5) packets. While all are occupied, every input ready is low.
- R6: Among waiting packets bound for the same output, the one accepted earliest leaves first.
- R7: An accepted packet whose relative address and mode equal those of a waiting packet that is not leaving in that cycle is merged into it. Mode 0 merges by bitwise OR and mode 1 by sum modulo 2^DATA_W. No new buffer is used.
- R8: At most one input is accepted per cycle. The lowest-numbered valid link wins, and injection is served only when no link is valid.
- R9: After reset no output is valid, `err_flag` is 0 and `drop_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | DIMS | Address of this node |
| inj_valid | input | 1 | Injection packet present |
| inj_ready | output | 1 | Injection packet taken this cycle |
| inj_dest | input | DIMS | Absolute destination node |
| inj_mode | input | 1 | Combine mode: 0 OR, 1 sum |
| inj_data | input | DATA_W | Payload |
| inj_par | input | 1 | Even-sense parity bit |
| lin_valid | input | DIMS | Per-dimension input link valid |
| lin_ready | output | DIMS | Per-dimension input link ready |
| lin_pkt | input | DIMS*PKT_W | Input link words, dimension d at slice d |
| lout_valid | output | DIMS | Per-dimension output link valid |
| lout_ready | input | DIMS | Per-dimension output link ready |
| lout_pkt | output | DIMS*PKT_W | Output link words, dimension d at slice d |
| ej_valid | output | 1 | Eject packet present |
| ej_ready | input | 1 | Local cluster takes the eject packet |
| ej_pkt | output | PKT_W | Eject word |
| err_flag | output | 1 | Sticky parity-error flag |
| drop_cnt | output | CNT_W | Saturating count of dropped packets |

## Verification
The bench targets several corner cases, each with the failure it would expose:
- Every destination and every relative address on every link of a four-dimension node are swept. A router that picked the highest differing bit or forgot to clear the crossed bit would send packets on the wrong link or loop them.
- Parity is checked in both senses. A router that kept even parity on the wire or did not flip it at ejection would produce words the next hop rejects.
- Five packets are parked on one blocked link. A design with a sixth phantom slot or wrong age order would show it when the pool is full and during the drain order.
- Two pairs of same-destination packets check that combining produces one packet with the OR or the wrapped sum, not two packets.
- Simultaneous requests check the fixed input priority.

// File: rtl/hc_pkg.sv
package hc_pkg;
   typedef enum logic {
      CMB_OR  = 1'b0,
      CMB_SUM = 1'b1
   } cmb_e;
endpackage

// File: rtl/hc_in_arb.sv
// Fixed-priority one-hot grant: lowest index wins.
module hc_in_arb #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   always_comb begin
      logic taken;
      taken = 1'b0;
      gnt   = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !taken) begin
            gnt[i] = 1'b1;
            taken  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/hc_lsb_port.sv
// Output port of one buffered packet: lowest set bit, or eject (index DIMS) when zero.
module hc_lsb_port #(
   parameter int DIMS = 12
) (
   input  logic [DIMS-1:0] rel,
   output logic [DIMS:0]   port
);
   always_comb begin
      logic found;
      found = 1'b0;
      port  = '0;
      for (int d = 0; d < DIMS; d++) begin
         if (rel[d] && !found) begin
            port[d] = 1'b1;
            found   = 1'b1;
         end
      end
      port[DIMS] = ~|rel;
   end
endmodule

// File: rtl/hc_age_pick.sv
// Picks the oldest candidate; older[j][i] set means slot j arrived before slot i.
module hc_age_pick #(
   parameter int NBUF = 5
) (
   input  logic [NBUF-1:0]            cand,
   input  logic [NBUF-1:0][NBUF-1:0]  older,
   output logic [NBUF-1:0]            pick
);
   always_comb begin
      for (int i = 0; i < NBUF; i++) begin
         logic beaten;
         beaten = 1'b0;
         for (int j = 0; j < NBUF; j++) begin
            if (cand[j] && older[j][i]) beaten = 1'b1;
         end
         pick[i] = cand[i] && !beaten;
      end
   end
endmodule

// File: rtl/hc_router.sv
module hc_router #(
   parameter int DIMS   = 12,
   parameter int DATA_W = 16,
   parameter int NBUF   = 5,
   parameter int CNT_W  = 8,
   localparam int PKT_W = DIMS + DATA_W + 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [DIMS-1:0]        node_id,
   input  logic                   inj_valid,
   output logic                   inj_ready,
   input  logic [DIMS-1:0]        inj_dest,
   input  logic                   inj_mode,
   input  logic [DATA_W-1:0]      inj_data,
   input  logic                   inj_par,
   input  logic [DIMS-1:0]        lin_valid,
   output logic [DIMS-1:0]        lin_ready,
   input  logic [DIMS*PKT_W-1:0]  lin_pkt,
   output logic [DIMS-1:0]        lout_valid,
   input  logic [DIMS-1:0]        lout_ready,
   output logic [DIMS*PKT_W-1:0]  lout_pkt,
   output logic                   ej_valid,
   input  logic                   ej_ready,
   output logic [PKT_W-1:0]       ej_pkt,
   output logic                   err_flag,
   output logic [CNT_W-1:0]       drop_cnt
);
   import hc_pkg::*;

   localparam int NIN  = DIMS + 1;   // links, then injection
   localparam int NOUT = DIMS + 1;   // links, then eject

   if (DIMS < 1 || DATA_W < 1 || NBUF < 2 || CNT_W < 1) begin : g_bad_param
      $error("hc_router: illegal parameter set");
   end

   // ---------------- input side ----------------
   logic [DIMS-1:0]   in_rel  [NIN];
   logic              in_mode [NIN];
   logic [DATA_W-1:0] in_data [NIN];
   logic [NIN-1:0]    in_ok;

   for (genvar d = 0; d < DIMS; d++) begin : g_lin
      logic [PKT_W-1:0] w;
      assign w          = lin_pkt[d*PKT_W +: PKT_W];
      assign in_rel[d]  = w[PKT_W-1 -: DIMS];
      assign in_mode[d] = w[DATA_W+1];
      assign in_data[d] = w[DATA_W:1];
      assign in_ok[d]   = ^w;              // wire sense: odd
   end
   assign in_rel[DIMS]  = inj_dest ^ node_id;
   assign in_mode[DIMS] = inj_mode;
   assign in_data[DIMS] = inj_data;
   assign in_ok[DIMS]   = ~^{inj_dest, inj_mode, inj_data, inj_par};  // local sense: even

   logic [NBUF-1:0] buf_v;
   logic [DIMS-1:0] buf_rel  [NBUF];
   logic            buf_mode [NBUF];
   logic [DATA_W-1:0] buf_data [NBUF];
   logic [NBUF-1:0][NBUF-1:0] older;

   logic [NIN-1:0] in_req, in_gnt, in_rdy;
   logic full, acc;
   assign in_req    = {inj_valid, lin_valid};
   assign full      = &buf_v;
   assign in_rdy    = full ? '0 : in_gnt;
   assign acc       = |in_rdy;
   assign lin_ready = in_rdy[DIMS-1:0];
   assign inj_ready = in_rdy[DIMS];

   hc_in_arb #(.N(NIN)) u_in_arb (.req(in_req), .gnt(in_gnt));

   logic [DIMS-1:0]   sel_rel;
   logic              sel_mode, sel_ok;
   logic [DATA_W-1:0] sel_data;
   always_comb begin
      sel_rel = '0; sel_mode = 1'b0; sel_data = '0; sel_ok = 1'b0;
      for (int i = 0; i < NIN; i++) begin
         if (in_gnt[i]) begin
            sel_rel  = in_rel[i];
            sel_mode = in_mode[i];
            sel_data = in_data[i];
            sel_ok   = in_ok[i];
         end
      end
   end

   // ---------------- output side ----------------
   logic [NOUT-1:0] tgt  [NBUF];
   logic [NBUF-1:0] cand [NOUT];
   logic [NBUF-1:0] pick [NOUT];
   logic [NOUT-1:0] out_rdy, out_v;
   logic [DIMS-1:0] out_rel  [NOUT];
   logic            out_mode [NOUT];
   logic [DATA_W-1:0] out_data [NOUT];
   logic [NBUF-1:0] depart;

   for (genvar b = 0; b < NBUF; b++) begin : g_tgt
      hc_lsb_port #(.DIMS(DIMS)) u_port (.rel(buf_rel[b]), .port(tgt[b]));
   end

   for (genvar o = 0; o < NOUT; o++) begin : g_out
      always_comb begin
         for (int b = 0; b < NBUF; b++) cand[o][b] = buf_v[b] && tgt[b][o];
      end
      hc_age_pick #(.NBUF(NBUF)) u_pick (.cand(cand[o]), .older(older), .pick(pick[o]));
   end

   assign out_rdy = {ej_ready, lout_ready};

   always_comb begin
      depart = '0;
      for (int o = 0; o < NOUT; o++) begin
         out_v[o] = |pick[o];
         out_rel[o] = '0; out_mode[o] = 1'b0; out_data[o] = '0;
         for (int b = 0; b < NBUF; b++) begin
            if (pick[o][b]) begin
               out_rel[o]  = buf_rel[b];
               out_mode[o] = buf_mode[b];
               out_data[o] = buf_data[b];
               if (out_rdy[o]) depart[b] = 1'b1;
            end
         end
      end
   end

   for (genvar d = 0; d < DIMS; d++) begin : g_lout
      logic [DIMS-1:0] r;
      assign r = out_rel[d] & ~(DIMS'(1) << d);
      assign lout_valid[d] = out_v[d];
      assign lout_pkt[d*PKT_W +: PKT_W] = {r, out_mode[d], out_data[d], ~^{r, out_mode[d], out_data[d]}};

      AST_LINK_ODD: assert property (@(posedge clk) disable iff (!rst_n)
         lout_valid[d] |-> (^lout_pkt[d*PKT_W +: PKT_W]) == 1'b1);            // R3
      AST_ROUTE_LSB: assert property (@(posedge clk) disable iff (!rst_n)
         lout_valid[d] |-> lout_pkt[d*PKT_W + PKT_W - DIMS + d] == 1'b0);     // R1
   end

   assign ej_valid = out_v[DIMS];
   assign ej_pkt   = {out_rel[DIMS], out_mode[DIMS], out_data[DIMS],
                      ^{out_rel[DIMS], out_mode[DIMS], out_data[DIMS]}};

   // ---------------- combine and allocate ----------------
   logic [NBUF-1:0] hit, hit_oh, free_oh;
   logic good, bad, merge, alloc;
   always_comb begin
      for (int b = 0; b < NBUF; b++)
         hit[b] = buf_v[b] && !depart[b] && (buf_rel[b] == sel_rel) && (buf_mode[b] == sel_mode);
   end
   hc_in_arb #(.N(NBUF)) u_hit_arb  (.req(hit),    .gnt(hit_oh));
   hc_in_arb #(.N(NBUF)) u_free_arb (.req(~buf_v), .gnt(free_oh));

   assign good  = acc && sel_ok;
   assign bad   = acc && !sel_ok;
   assign merge = good && |hit_oh;
   assign alloc = good && !merge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_v    <= '0;
         older    <= '0;
         err_flag <= 1'b0;
         drop_cnt <= '0;
         for (int b = 0; b < NBUF; b++) begin
            buf_rel[b]  <= '0;
            buf_mode[b] <= 1'b0;
            buf_data[b] <= '0;
         end
      end else begin
         for (int b = 0; b < NBUF; b++) begin
            if (depart[b]) buf_v[b] <= 1'b0;
            if (alloc && free_oh[b]) begin
               buf_v[b]    <= 1'b1;
               buf_rel[b]  <= sel_rel;
               buf_mode[b] <= sel_mode;
               buf_data[b] <= sel_data;
               for (int j = 0; j < NBUF; j++) begin
                  older[j][b] <= (j != b);
                  older[b][j] <= 1'b0;
               end
            end
            if (merge && hit_oh[b]) begin
               if (sel_mode == CMB_SUM) buf_data[b] <= buf_data[b] + sel_data;
               else                     buf_data[b] <= buf_data[b] | sel_data;
            end
         end
         if (bad) begin
            err_flag <= 1'b1;
            if (drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (&buf_v) |-> !(|{inj_ready, lin_ready}));                          // R5
   AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({inj_ready, lin_ready}));                                 // R8
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);                                            // R4
   AST_EJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ej_valid |-> ej_pkt[PKT_W-1 -: DIMS] == '0);                       // R2
endmodule

// File: tb/tb_hc_router.sv
module tb_hc_router;
   localparam int CLK_P  = 10;
   localparam int DIMS   = 4;
   localparam int DATA_W = 8;
   localparam int NBUF   = 5;
   localparam int CNT_W  = 8;
   localparam int PKT_W  = DIMS + DATA_W + 2;
   localparam logic [DIMS-1:0] NODE = 4'b0101;

   logic clk = 0, rst_n = 0;
   logic [DIMS-1:0] node_id = NODE;
   logic inj_valid = 0, inj_ready, inj_mode = 0, inj_par = 0;
   logic [DIMS-1:0] inj_dest = '0;
   logic [DATA_W-1:0] inj_data = '0;
   logic [DIMS-1:0] lin_valid = '0, lin_ready;
   logic [DIMS*PKT_W-1:0] lin_pkt = '0;
   logic [DIMS-1:0] lout_valid, lout_ready = '1;
   logic [DIMS*PKT_W-1:0] lout_pkt;
   logic ej_valid, ej_ready = 1;
   logic [PKT_W-1:0] ej_pkt;
   logic err_flag;
   logic [CNT_W-1:0] drop_cnt;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   hc_router #(.DIMS(DIMS), .DATA_W(DATA_W), .NBUF(NBUF), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .node_id(node_id),
      .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_dest(inj_dest),
      .inj_mode(inj_mode), .inj_data(inj_data), .inj_par(inj_par),
      .lin_valid(lin_valid), .lin_ready(lin_ready), .lin_pkt(lin_pkt),
      .lout_valid(lout_valid), .lout_ready(lout_ready), .lout_pkt(lout_pkt),
      .ej_valid(ej_valid), .ej_ready(ej_ready), .ej_pkt(ej_pkt),
      .err_flag(err_flag), .drop_cnt(drop_cnt));

   always #(CLK_P/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [PKT_W-1:0] wword(input logic [DIMS-1:0] r, input logic m, input logic [DATA_W-1:0] dt);
      return {r, m, dt, ~^{r, m, dt}};   // odd total
   endfunction
   function automatic logic [PKT_W-1:0] eword(input logic [DIMS-1:0] r, input logic m, input logic [DATA_W-1:0] dt);
      return {r, m, dt, ^{r, m, dt}};    // even total
   endfunction

   task automatic inject(input logic [DIMS-1:0] dst, input logic m, input logic [DATA_W-1:0] dt, input bit badpar);
      @(negedge clk);
      inj_dest = dst; inj_mode = m; inj_data = dt;
      inj_par  = (^{dst, m, dt}) ^ badpar;
      inj_valid = 1;
      @(negedge clk);
      inj_valid = 0;
   endtask

   task automatic send_link(input int i, input logic [DIMS-1:0] r, input logic m, input logic [DATA_W-1:0] dt, input bit badpar);
      @(negedge clk);
      lin_pkt[i*PKT_W +: PKT_W] = wword(r, m, dt) ^ PKT_W'(badpar);
      lin_valid[i] = 1;
      @(negedge clk);
      lin_valid[i] = 0;
   endtask

   // Called at the negedge after acceptance: expects the packet on its route.
   task automatic expect_route(input logic [DIMS-1:0] r, input logic m, input logic [DATA_W-1:0] dt, input string req);
      int d;
      d = -1;
      for (int k = DIMS-1; k >= 0; k--) if (r[k]) d = k;
      check($countones({ej_valid, lout_valid}) == 1, req, {ej_valid, lout_valid}, 1);
      if (d < 0) begin
         check(ej_valid && ej_pkt == eword('0, m, dt), {req, " eject"}, ej_pkt, eword('0, m, dt));
      end else begin
         logic [DIMS-1:0] rr;
         rr = r & ~(DIMS'(1) << d);
         check(lout_valid[d] && lout_pkt[d*PKT_W +: PKT_W] == wword(rr, m, dt), {req, " link"},
               lout_pkt[d*PKT_W +: PKT_W], wword(rr, m, dt));
      end
   endtask

   initial begin
      #(CLK_P*100000);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R9 reset state
      check(!ej_valid && lout_valid == 0, "R9 outputs idle", {ej_valid, lout_valid}, 0);
      check(!err_flag && drop_cnt == 0, "R9 err/cnt clear", {err_flag, drop_cnt}, 0);

      // R1 R2 R3: every destination through the injection port
      for (int dst = 0; dst < (1 << DIMS); dst++) begin
         logic [DATA_W-1:0] dt;
         dt = DATA_W'(dst * 7 + 1);
         inject(DIMS'(dst), dst[0], dt, 0);
         expect_route(DIMS'(dst) ^ NODE, dst[0], dt, "R1 R2 R3 inject");
         @(negedge clk);
      end

      // R1 R2 R3: every relative address on every input link
      for (int i = 0; i < DIMS; i++) begin
         for (int r = 0; r < (1 << DIMS); r++) begin
            logic [DATA_W-1:0] dt;
            dt = DATA_W'(i * 16 + r + 3);
            send_link(i, DIMS'(r), r[1], dt, 0);
            expect_route(DIMS'(r), r[1], dt, "R1 R2 R3 link");
            @(negedge clk);
         end
      end

      // R4: bad parity on a link, then on injection
      send_link(2, 4'b0100, 0, 8'h5A, 1);
      check(ej_valid == 0 && lout_valid == 0, "R4 dropped link pkt", {ej_valid, lout_valid}, 0);
      check(err_flag == 1 && drop_cnt == 1, "R4 flag/count 1", {err_flag, drop_cnt}, {1'b1, 8'd1});
      inject(NODE, 1, 8'h33, 1);
      check(ej_valid == 0 && lout_valid == 0, "R4 dropped inject pkt", {ej_valid, lout_valid}, 0);
      check(drop_cnt == 2, "R4 count 2", drop_cnt, 2);
      inject(NODE ^ 4'b1000, 0, 8'h44, 0);
      expect_route(4'b1000, 0, 8'h44, "R4 good after error");
      check(err_flag == 1, "R4 flag sticky", err_flag, 1);
      @(negedge clk);

      // R8: priority among simultaneous inputs
      lin_pkt[0*PKT_W +: PKT_W] = wword(4'b0000, 0, 8'h01);
      lin_pkt[2*PKT_W +: PKT_W] = wword(4'b0000, 0, 8'h02);
      inj_dest = NODE; inj_mode = 0; inj_data = 8'h03; inj_par = ^{NODE, 1'b0, 8'h03};
      lin_valid = 4'b0101; inj_valid = 1;
      #1;
      check(lin_ready == 4'b0001 && !inj_ready, "R8 link0 first", {inj_ready, lin_ready}, 5'b00001);
      @(negedge clk);
      lin_valid[0] = 0;
      #1;
      check(lin_ready == 4'b0100 && !inj_ready, "R8 link2 next", {inj_ready, lin_ready}, 5'b00100);
      @(negedge clk);
      lin_valid[2] = 0;
      #1;
      check(inj_ready == 1, "R8 inject last", inj_ready, 1);
      @(negedge clk);
      inj_valid = 0;
      repeat (3) @(negedge clk);

      // R5 R6: five packets parked on blocked link 0, oldest drains first
      lout_ready = '0; ej_ready = 0;
      for (int k = 0; k < NBUF; k++) inject(DIMS'(2*k + 1) ^ NODE, 0, DATA_W'(8'hA0 + k), 0);
      inj_dest = NODE ^ 4'b0010; inj_mode = 0; inj_data = 8'h77; inj_par = ^{NODE ^ 4'b0010, 1'b0, 8'h77};
      inj_valid = 1; lin_valid[3] = 1; lin_pkt[3*PKT_W +: PKT_W] = wword(4'b0100, 0, 8'h66);
      #1;
      check(!inj_ready && lin_ready == 0, "R5 full blocks all", {inj_ready, lin_ready}, 0);
      @(negedge clk);
      inj_valid = 0; lin_valid = '0;
      lout_ready[0] = 1;
      for (int k = 0; k < NBUF; k++) begin
         #1;
         check(lout_valid[0] && lout_pkt[0 +: PKT_W] == wword(DIMS'(2*k), 0, DATA_W'(8'hA0 + k)),
               "R6 oldest first", lout_pkt[0 +: PKT_W], wword(DIMS'(2*k), 0, DATA_W'(8'hA0 + k)));
         @(negedge clk);
      end
      check(lout_valid[0] == 0, "R6 drained", lout_valid, 0);

      // R7: OR combine
      lout_ready = '0;
      inject(NODE ^ 4'b0110, 0, 8'h0C, 0);
      inject(NODE ^ 4'b0110, 0, 8'h0A, 0);
      check(lout_valid[1] && lout_pkt[1*PKT_W +: PKT_W] == wword(4'b0100, 0, 8'h0E), "R7 OR merge",
            lout_pkt[1*PKT_W +: PKT_W], wword(4'b0100, 0, 8'h0E));
      lout_ready[1] = 1;
      @(negedge clk);
      check(lout_valid[1] == 0, "R7 OR single packet", lout_valid, 0);
      lout_ready = '0;
      // R7: sum combine with wrap
      inject(NODE ^ 4'b0110, 1, 8'h90, 0);
      inject(NODE ^ 4'b0110, 1, 8'h85, 0);
      check(lout_valid[1] && lout_pkt[1*PKT_W +: PKT_W] == wword(4'b0100, 1, 8'h15), "R7 sum merge",
            lout_pkt[1*PKT_W +: PKT_W], wword(4'b0100, 1, 8'h15));
      lout_ready[1] = 1;
      @(negedge clk);
      check(lout_valid[1] == 0, "R7 sum single packet", lout_valid, 0);
      lout_ready = '1; ej_ready = 1;
      repeat (2) @(negedge clk);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule